// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. A lookup presents a 32-bit virtual address, a 6-bit address-space identifier and the current privilege mode. In the same cycle it answers with hit or miss, the translated physical address, the entry's flags, and any address error, protection fault or multiple match. Each entry is tagged with an address-space identifier, so switching between processes needs no flush. An entry marked global matches every identifier.

The top three virtual address bits pick a segment. Two segments are translated through the entries. Two are untranslated kernel windows onto physical memory, one cached and one uncached. User mode may not touch any kernel segment.

Software fills entries through a write port. The write goes either to an explicit slot or to the slot named by a free-running down-counter. The counter never selects the low reserved slots, so entries written there stay resident. No port of the block carries a data stream. Lookups are combinational, and writes are single-cycle strobes that are always accepted. For these reasons every pin is a plain signal and the block applies no back-pressure.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so any translated lookup reports a miss, and `rand_idx` reads 63.
- R2: A lookup in a translated segment hits when some valid entry has the same virtual page number (`lk_vaddr[31:12]`) and the same identifier. On a hit, `lk_paddr` is that entry's physical page followed by `lk_vaddr[11:0]`, and `lk_index` is the slot. `lk_hit` and `lk_miss` are never both high.
- R3: An entry that is not global and whose identifier differs from `lk_asid` does not match.
- R4: An entry written with `wr_global=1` matches under any `lk_asid`.
- R5: Segments are decoded from the top three address bits. Values 0xx and 11x are translated (`lk_mapped=1`). Value 100 is untranslated and cached. Value 101 is untranslated and uncached (`lk_cached=0`). For both untranslated values, `lk_paddr` is the address with its top three bits cleared, and `lk_hit` and `lk_miss` are both 0.
- R6: With `lk_user=1`, an address whose top bit is 1 raises `lk_addr_err`, and `lk_hit` and `lk_miss` are both 0.
- R7: Access rights are two bits. Bit 0 allows reads and bit 1 allows writes. A hit whose access (`lk_store=0` for a read, `lk_store=1` for a write) is not allowed raises `lk_prot_fault`.
- R8: A lookup with `lk_en=1` that hits without a fault sets the entry's referenced flag. If it is a store, it also sets the dirty flag. The flags are visible on `lk_ref`/`lk_dirty` from the next lookup onward. A faulting store leaves the dirty flag clear.
- R9: When more than one valid entry matches, the lowest slot supplies the result and `lk_multi` is 1.
- R10: `rand_idx` decrements by one every cycle. From 8 it wraps to 63, so it stays within 8..63.
- R11: A write with `wr_use_rand=0` loads slot `wr_index`. A write with `wr_use_rand=1` loads the slot shown on `rand_idx` in that cycle, which is never one of slots 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_en | input | 1 | Lookup is a real access (enables flag updates) |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_store | input | 1 | 1 = write access, 0 = read access |
| lk_asid | input | 6 | Address-space identifier of the lookup |
| lk_vaddr | input | 32 | Virtual address |
| lk_hit | output | 1 | Translated lookup matched |
| lk_miss | output | 1 | Translated lookup found no match |
| lk_multi | output | 1 | More than one entry matched |
| lk_index | output | 6 | Slot that supplied the hit |
| lk_paddr | output | 32 | Physical address |
| lk_mapped | output | 1 | Segment is translated |
| lk_cached | output | 1 | Access may be cached |
| lk_addr_err | output | 1 | Kernel segment accessed in user mode |
| lk_prot_fault | output | 1 | Hit whose rights forbid the access |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| lk_ref | output | 1 | Referenced flag of the hit entry |
| lk_rights | output | 2 | Rights of the hit entry |
| wr_en | input | 1 | Write an entry this cycle |
| wr_use_rand | input | 1 | Target the random slot instead of wr_index |
| wr_index | input | 6 | Explicit target slot |
| wr_vpn | input | 20 | Virtual page number |
| wr_asid | input | 6 | Identifier tag |
| wr_global | input | 1 | Match any identifier |
| wr_ppn | input | 20 | Physical page number |
| wr_entry_valid | input | 1 | Valid flag |
| wr_dirty | input | 1 | Initial dirty flag |
| wr_ref | input | 1 | Initial referenced flag |
| wr_rights | input | 2 | Rights (bit 0 read, bit 1 write) |
| rand_idx | output | 6 | Current random replacement slot |

## Verification
The bench uses the default parameters: 64 slots, 8 reserved slots, a 20-bit page number with a 12-bit offset, and 6-bit identifiers. With 64 slots the down-counter covers its whole 63..8 range in 56 cycles, so the bench watches at least one full wrap. It also writes through the random slot and confirms where the entry lands. Deliberately overlapping entries in slots 10 and 12 exercise the lowest-slot priority rule. The full 32-bit address makes all four segment codes reachable, including the user-mode address error.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  typedef enum logic [1:0] {
    SEG_USER    = 2'd0,
    SEG_KPHYS_C = 2'd1,
    SEG_KPHYS_U = 2'd2,
    SEG_KVIRT   = 2'd3
  } seg_e;

  localparam int RIGHT_RD = 0;
  localparam int RIGHT_WR = 1;
endpackage

// File: rtl/asid_tlb_segdec.sv
module asid_tlb_segdec
  import asid_tlb_pkg::*;
(
  input  logic [2:0] top_bits,
  input  logic       user,
  output seg_e       seg,
  output logic       mapped,
  output logic       cached,
  output logic       addr_err
);
  always_comb begin
    if (!top_bits[2])          seg = SEG_USER;
    else if (top_bits[1])      seg = SEG_KVIRT;
    else if (top_bits[0])      seg = SEG_KPHYS_U;
    else                       seg = SEG_KPHYS_C;
  end

  assign mapped   = (seg == SEG_USER) || (seg == SEG_KVIRT);
  assign cached   = (seg != SEG_KPHYS_U);
  assign addr_err = user && (seg != SEG_USER);
endmodule

// File: rtl/asid_tlb_match.sv
module asid_tlb_match #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 6,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [VPN_W-1:0]           q_vpn,
  input  logic [ASID_W-1:0]          q_asid,
  input  logic [N-1:0][VPN_W-1:0]    t_vpn,
  input  logic [N-1:0][ASID_W-1:0]   t_asid,
  input  logic [N-1:0]               t_glob,
  input  logic [N-1:0]               t_val,
  output logic                       any,
  output logic                       multi,
  output logic [IDX_W-1:0]           idx
);
  logic [N-1:0] m;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign m[g] = t_val[g] && (t_vpn[g] == q_vpn) &&
                  (t_glob[g] || (t_asid[g] == q_asid));
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |m;
  assign multi = |(m & (m - N'(1)));
endmodule

// File: rtl/asid_tlb_rand.sv
module asid_tlb_rand #(
  parameter int N     = 64,
  parameter int WIRED = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] cnt
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N - 1);
  localparam logic [IDX_W-1:0] BOT = IDX_W'(WIRED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= TOP;
    else if (cnt == BOT) cnt <= TOP;
    else                 cnt <= cnt - IDX_W'(1);
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int N      = 64,
  parameter int WIRED  = 8,
  parameter int VPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 6,
  localparam int IDX_W = $clog2(N),
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic              lk_user,
  input  logic              lk_store,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_multi,
  output logic [IDX_W-1:0]  lk_index,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_mapped,
  output logic              lk_cached,
  output logic              lk_addr_err,
  output logic              lk_prot_fault,
  output logic              lk_dirty,
  output logic              lk_ref,
  output logic [1:0]        lk_rights,
  input  logic              wr_en,
  input  logic              wr_use_rand,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_entry_valid,
  input  logic              wr_dirty,
  input  logic              wr_ref,
  input  logic [1:0]        wr_rights,
  output logic [IDX_W-1:0]  rand_idx
);
  logic [N-1:0][VPN_W-1:0]  e_vpn;
  logic [N-1:0][ASID_W-1:0] e_asid;
  logic [N-1:0][PPN_W-1:0]  e_ppn;
  logic [N-1:0][1:0]        e_rights;
  logic [N-1:0]             e_glob;
  logic [N-1:0]             e_val;
  logic [N-1:0]             e_dirty;
  logic [N-1:0]             e_ref;

  seg_e             seg;
  logic             any_match, multi_raw, translate, allowed, update;
  logic [IDX_W-1:0] m_idx, wr_slot;
  logic [VPN_W-1:0] q_vpn;

  assign q_vpn = lk_vaddr[VA_W-1 -: VPN_W];

  asid_tlb_segdec u_seg (
    .top_bits (lk_vaddr[VA_W-1 -: 3]),
    .user     (lk_user),
    .seg      (seg),
    .mapped   (lk_mapped),
    .cached   (lk_cached),
    .addr_err (lk_addr_err)
  );

  asid_tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_match (
    .q_vpn  (q_vpn),
    .q_asid (lk_asid),
    .t_vpn  (e_vpn),
    .t_asid (e_asid),
    .t_glob (e_glob),
    .t_val  (e_val),
    .any    (any_match),
    .multi  (multi_raw),
    .idx    (m_idx)
  );

  asid_tlb_rand #(.N(N), .WIRED(WIRED), .IDX_W(IDX_W)) u_rand (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (rand_idx)
  );

  assign translate     = lk_mapped && !lk_addr_err;
  assign lk_hit        = translate && any_match;
  assign lk_miss       = translate && !any_match;
  assign lk_multi      = lk_hit && multi_raw;
  assign lk_index      = lk_hit ? m_idx : '0;
  assign lk_rights     = lk_hit ? e_rights[m_idx] : 2'b00;
  assign lk_dirty      = lk_hit && e_dirty[m_idx];
  assign lk_ref        = lk_hit && e_ref[m_idx];
  assign allowed       = lk_store ? lk_rights[RIGHT_WR] : lk_rights[RIGHT_RD];
  assign lk_prot_fault = lk_hit && !allowed;

  always_comb begin
    if (lk_hit)
      lk_paddr = {e_ppn[m_idx], lk_vaddr[OFF_W-1:0]};
    else if (!lk_mapped)
      lk_paddr = PA_W'(lk_vaddr[VA_W-4:0]);
    else
      lk_paddr = '0;
  end

  assign update  = lk_en && lk_hit && !lk_prot_fault;
  assign wr_slot = wr_use_rand ? rand_idx : wr_index;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_val   <= '0;
      e_dirty <= '0;
      e_ref   <= '0;
    end else begin
      if (update) begin
        e_ref[m_idx] <= 1'b1;
        if (lk_store) e_dirty[m_idx] <= 1'b1;
      end
      if (wr_en) begin
        e_val[wr_slot]   <= wr_entry_valid;
        e_dirty[wr_slot] <= wr_dirty;
        e_ref[wr_slot]   <= wr_ref;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vpn[wr_slot]    <= wr_vpn;
      e_asid[wr_slot]   <= wr_asid;
      e_glob[wr_slot]   <= wr_global;
      e_ppn[wr_slot]    <= wr_ppn;
      e_rights[wr_slot] <= wr_rights;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int N     = 64,
  parameter int WIRED = 8,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_en,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_multi,
  input logic             lk_mapped,
  input logic             lk_addr_err,
  input logic             lk_prot_fault,
  input logic [IDX_W-1:0] lk_index,
  input logic             wr_en,
  input logic [IDX_W-1:0] rand_idx,
  input logic [N-1:0]     e_ref
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss)); // R2
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_mapped |-> (!lk_hit && !lk_miss)); // R5
  AST_ADDR_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_addr_err |-> (!lk_hit && !lk_miss)); // R6
  AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_prot_fault |-> lk_hit); // R7
  AST_REF_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && lk_hit && !lk_prot_fault && !wr_en) |=> e_ref[$past(lk_index)]); // R8
  AST_MULTI_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit); // R9
  AST_RAND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rand_idx >= IDX_W'(WIRED)) && (rand_idx <= IDX_W'(N - 1))); // R10
  AST_RAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rand_idx != IDX_W'(WIRED)) |=> (rand_idx == $past(rand_idx) - IDX_W'(1))); // R10
  AST_RAND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rand_idx == IDX_W'(WIRED)) |=> (rand_idx == IDX_W'(N - 1))); // R10
endmodule

bind asid_tlb asid_tlb_chk #(.N(N), .WIRED(WIRED), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_en         (lk_en),
  .lk_hit        (lk_hit),
  .lk_miss       (lk_miss),
  .lk_multi      (lk_multi),
  .lk_mapped     (lk_mapped),
  .lk_addr_err   (lk_addr_err),
  .lk_prot_fault (lk_prot_fault),
  .lk_index      (lk_index),
  .wr_en         (wr_en),
  .rand_idx      (rand_idx),
  .e_ref         (e_ref)
);

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en = 1'b0, lk_user = 1'b0, lk_store = 1'b0;
  logic [5:0]  lk_asid = '0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss, lk_multi, lk_mapped, lk_cached;
  logic        lk_addr_err, lk_prot_fault, lk_dirty, lk_ref;
  logic [5:0]  lk_index;
  logic [31:0] lk_paddr;
  logic [1:0]  lk_rights;
  logic        wr_en = 1'b0, wr_use_rand = 1'b0, wr_global = 1'b0;
  logic        wr_entry_valid = 1'b0, wr_dirty = 1'b0, wr_ref = 1'b0;
  logic [5:0]  wr_index = '0, wr_asid = '0;
  logic [19:0] wr_vpn = '0, wr_ppn = '0;
  logic [1:0]  wr_rights = '0;
  logic [5:0]  rand_idx;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  asid_tlb u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic use_rand, input logic [19:0] vpn,
                    input logic [5:0] asid, input logic glob, input logic [19:0] ppn,
                    input logic [1:0] rights, input logic d, input logic r);
    wr_en = 1'b1; wr_use_rand = use_rand; wr_index = idx; wr_vpn = vpn;
    wr_asid = asid; wr_global = glob; wr_ppn = ppn; wr_rights = rights;
    wr_entry_valid = 1'b1; wr_dirty = d; wr_ref = r;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drives a lookup at a negedge, samples 1 ns later, ends at the next negedge
  task automatic look(input logic [31:0] va, input logic [5:0] asid,
                      input logic user, input logic store, input logic en);
    lk_vaddr = va; lk_asid = asid; lk_user = user; lk_store = store; lk_en = en;
    #1;
  endtask

  task automatic look_end();
    @(negedge clk);
    lk_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rand reset", 32'(rand_idx), 32'd63);
    look(32'h1234_5ABC, 6'd1, 1'b0, 1'b0, 1'b0);
    check("R1 miss after reset", 32'(lk_miss), 1);
    check("R1 no hit after reset", 32'(lk_hit), 0);
    look_end();
  endtask

  task automatic t_rand();
    logic [5:0] prev;
    int wraps = 0;
    for (int i = 0; i < 70; i++) begin
      prev = rand_idx;
      @(negedge clk);
      check("R10 rand step", 32'(rand_idx), (prev == 6'd8) ? 32'd63 : 32'(prev - 6'd1));
      if (prev == 6'd8) wraps++;
    end
    check("R10 saw wrap", 32'(wraps > 0), 1);
  endtask

  task automatic t_basic();
    wr(6'd3, 1'b0, 20'h12345, 6'd5, 1'b0, 20'h00777, 2'b11, 1'b0, 1'b0);
    look(32'h1234_5ABC, 6'd5, 1'b0, 1'b0, 1'b0);
    check("R2 hit", 32'(lk_hit), 1);
    check("R2 paddr", lk_paddr, 32'h0077_7ABC);
    check("R11 indexed slot", 32'(lk_index), 3);
    check("R2 no miss", 32'(lk_miss), 0);
    look_end();
  endtask

  task automatic t_asid();
    look(32'h1234_5ABC, 6'd6, 1'b0, 1'b0, 1'b0);
    check("R3 other asid misses", 32'(lk_miss), 1);
    look_end();
    wr(6'd4, 1'b0, 20'h0AAAA, 6'd9, 1'b1, 20'h00321, 2'b01, 1'b0, 1'b0);
    look(32'h0AAA_A010, 6'd33, 1'b0, 1'b0, 1'b0);
    check("R4 global hit", 32'(lk_hit), 1);
    check("R4 global paddr", lk_paddr, 32'h0032_1010);
    look_end();
  endtask

  task automatic t_segments();
    look(32'h8000_1234, 6'd5, 1'b0, 1'b0, 1'b0);
    check("R5 kseg cached mapped", 32'(lk_mapped), 0);
    check("R5 kseg cached flag", 32'(lk_cached), 1);
    check("R5 kseg cached paddr", lk_paddr, 32'h0000_1234);
    check("R5 kseg cached no hit/miss", 32'({lk_hit, lk_miss}), 0);
    look_end();
    look(32'hA000_1234, 6'd5, 1'b0, 1'b0, 1'b0);
    check("R5 kseg uncached flag", 32'(lk_cached), 0);
    check("R5 kseg uncached paddr", lk_paddr, 32'h0000_1234);
    look_end();
    wr(6'd5, 1'b0, 20'hC0010, 6'd5, 1'b0, 20'h00ABC, 2'b11, 1'b0, 1'b0);
    look(32'hC001_0004, 6'd5, 1'b0, 1'b0, 1'b0);
    check("R5 kernel virtual translated", 32'({lk_mapped, lk_hit}), 32'b11);
    check("R5 kernel virtual paddr", lk_paddr, 32'h00AB_C004);
    look_end();
  endtask

  task automatic t_addr_err();
    look(32'hC001_0004, 6'd5, 1'b1, 1'b0, 1'b0);
    check("R6 user kernel addr err", 32'(lk_addr_err), 1);
    check("R6 no hit/miss", 32'({lk_hit, lk_miss}), 0);
    look_end();
    look(32'h8000_0000, 6'd5, 1'b1, 1'b0, 1'b0);
    check("R6 user kphys addr err", 32'(lk_addr_err), 1);
    look_end();
    look(32'h1234_5ABC, 6'd5, 1'b1, 1'b0, 1'b0);
    check("R6 user useg ok", 32'({lk_addr_err, lk_hit}), 32'b01);
    look_end();
  endtask

  task automatic t_prot_flags();
    // slot 4 is read-only (rights 01)
    look(32'h0AAA_A010, 6'd1, 1'b0, 1'b1, 1'b1);
    check("R7 store to read-only faults", 32'(lk_prot_fault), 1);
    look_end();
    look(32'h0AAA_A010, 6'd1, 1'b0, 1'b0, 1'b0);
    check("R7 load of read-only ok", 32'(lk_prot_fault), 0);
    check("R8 faulting store leaves dirty clear", 32'(lk_dirty), 0);
    look_end();
    wr(6'd6, 1'b0, 20'h55555, 6'd2, 1'b0, 20'h00999, 2'b10, 1'b0, 1'b0);
    look(32'h5555_5000, 6'd2, 1'b0, 1'b0, 1'b0);
    check("R7 load of write-only faults", 32'(lk_prot_fault), 1);
    look_end();
    // slot 3 rw, ref/dirty clear
    look(32'h1234_5ABC, 6'd5, 1'b0, 1'b0, 1'b1);
    check("R8 ref clear before", 32'(lk_ref), 0);
    look_end();
    look(32'h1234_5ABC, 6'd5, 1'b0, 1'b1, 1'b1);
    check("R8 ref set by hit", 32'(lk_ref), 1);
    check("R8 dirty clear before store", 32'(lk_dirty), 0);
    look_end();
    look(32'h1234_5ABC, 6'd5, 1'b0, 1'b0, 1'b0);
    check("R8 dirty set by store", 32'(lk_dirty), 1);
    look_end();
  endtask

  task automatic t_multi();
    wr(6'd12, 1'b0, 20'h77777, 6'd7, 1'b0, 20'h00C0C, 2'b11, 1'b0, 1'b0);
    look(32'h7777_7008, 6'd7, 1'b0, 1'b0, 1'b0);
    check("R9 single no multi", 32'(lk_multi), 0);
    look_end();
    wr(6'd10, 1'b0, 20'h77777, 6'd7, 1'b0, 20'h00A0A, 2'b11, 1'b0, 1'b0);
    look(32'h7777_7008, 6'd7, 1'b0, 1'b0, 1'b0);
    check("R9 multi flag", 32'(lk_multi), 1);
    check("R9 lowest slot", 32'(lk_index), 10);
    check("R9 lowest paddr", lk_paddr, 32'h00A0_A008);
    look_end();
  endtask

  task automatic t_rand_write();
    logic [5:0] slot;
    slot = rand_idx;
    wr(6'd1, 1'b1, 20'h3C3C3, 6'd8, 1'b0, 20'h00456, 2'b11, 1'b0, 1'b0);
    look(32'h3C3C_3100, 6'd8, 1'b0, 1'b0, 1'b0);
    check("R11 random slot", 32'(lk_index), 32'(slot));
    check("R11 random not reserved", 32'(lk_index >= 6'd8), 1);
    look_end();
    look(32'h1234_5ABC, 6'd5, 1'b0, 1'b0, 1'b0);
    check("R11 wired slot kept", 32'({lk_hit, lk_index}), 32'({1'b1, 6'd3}));
    look_end();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rand();
    t_basic();
    t_asid();
    t_segments();
    t_addr_err();
    t_prot_flags();
    t_multi();
    t_rand_write();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule